// File: doc/BRIEF.md
# Offset Calibration and Reset Sequencer

This block sits between a two-channel decimated sample stream and the serial output stage of an audio converter. While the active-low reset is held, the whole digital path stays powered down: no data is valid and every output is held at zero. When reset is released, the block runs one offset calibration cycle. The cycle is timed in rising edges of the sample clock. At its end, the block keeps the current raw sample of each channel as that channel's offset. From then on it subtracts the offset from every later sample and clamps the difference to the 24-bit two's-complement range.

Calibration length is set by parameters. It doubles when double-rate operation is selected, and it grows by one sample period when the block runs as a timing slave. A select input decides what the front end presents during calibration: the live inputs or the internal common-mode reference. The block does not use this select in its arithmetic. It only forwards it to the front end while calibration runs.

A phase monitor counts master-clock cycles between sample-clock rising edges. If a period comes out shorter or longer than expected, the block restarts calibration by itself.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst_n` is low, `cal` and `out_valid` are 0 and both outputs are 0.
- R2: On the second master-clock edge after `rst_n` rises, `cal` is 1. It stays 1 until the cycle after the calibration-ending sample-clock rising edge. In normal-rate master operation that edge is number CAL_EDGES after release.
- R3: With `dbl_rate` = 1, both the calibration-ending edge count and the valid-start edge count are twice their normal-rate values.
- R4: With `slave_mode` = 1, both edge counts are one larger than in master operation.
- R5: `out_valid` rises in the cycle after the valid-start edge (number VALID_EDGES in normal-rate master operation). It is never 1 while `cal` is 1.
- R6: Each channel's offset is the raw sample present at the calibration-ending edge. Raw samples at earlier edges have no effect.
- R7: Each valid output equals raw minus offset as signed 24-bit values. A result above the range gives 0x7FFFFF. A result below the range gives 0x800000.
- R8: Whenever `out_valid` is 0, including the interval between `cal` falling and `out_valid` rising, both outputs are 0.
- R9: Master-clock cycles between sample-clock rising edges must equal MCLK_PER_FS, or half of it when `dbl_rate` = 1. A shorter or longer period sets `cal` = 1 and `out_valid` = 0 in the next cycle and restarts the edge count from zero. The edge that ends a short period is not counted.
- R10: `cal_src` equals `cal_src_live` while `cal` is 1, and is 1 (live inputs) otherwise.
- R11: Outputs change only one master-clock cycle after a sample-clock rising edge. At that point they carry the sample present at that edge, or zero if that edge does not leave the block running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low power-down reset, asynchronous |
| lrck | input | 1 | Sample clock; a rising edge marks one sample period |
| dbl_rate | input | 1 | 1 selects double-rate operation |
| slave_mode | input | 1 | 1 selects timing-slave operation |
| cal_src_live | input | 1 | Calibration source: 1 live inputs, 0 common-mode reference |
| raw_l | input | 24 | Raw left sample, two's complement |
| raw_r | input | 24 | Raw right sample, two's complement |
| out_l | output | 24 | Corrected left sample |
| out_r | output | 24 | Corrected right sample |
| out_valid | output | 1 | Corrected samples are valid |
| cal | output | 1 | Calibration in progress |
| cal_src | output | 1 | Source select driven to the front end |

## Verification
The bench builds the block with CAL_EDGES = 6, VALID_EDGES = 10 and MCLK_PER_FS = 8. At these values the full calibration timeline can be walked one sample edge at a time in all four rate and role combinations, whose edge counts are 6/10, 7/11, 12/20 and 13/21. The 8-cycle frame leaves room for short, long and missing sample-clock periods in both rates. Offsets at the extremes of the 24-bit range drive the subtraction into both saturation limits.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_CAL, ST_SETTLE, ST_RUN} ocs_state_e;

  // Edge count after release for a given base count and operating mode
  function automatic int unsigned ocs_len(int unsigned base, logic dbl, logic slave);
    int unsigned n;
    n = dbl ? 2 * base : base;
    return n + (slave ? 1 : 0);
  endfunction
endpackage

// File: rtl/ocs_phase_mon.sv
module ocs_phase_mon #(
  parameter int unsigned PER = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic dbl,
  output logic edge_o,
  output logic err_o
);
  localparam int unsigned PW = $clog2(PER + 1);

  logic          lrck_q;
  logic          seen;
  logic [PW-1:0] pcnt;
  logic [PW-1:0] last_idx;

  assign last_idx = dbl ? PW'(PER / 2 - 1) : PW'(PER - 1);
  assign edge_o   = lrck && !lrck_q;
  assign err_o    = seen && (edge_o ? (pcnt != last_idx) : (pcnt == last_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      seen   <= 1'b0;
      pcnt   <= '0;
    end else begin
      lrck_q <= lrck;
      if (edge_o) begin
        seen <= 1'b1;
        pcnt <= '0;
      end else if (err_o) begin
        seen <= 1'b0;
        pcnt <= '0;
      end else if (seen) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ocs_cal_fsm.sv
module ocs_cal_fsm
  import ocs_pkg::*;
#(
  parameter int unsigned CAL_EDGES   = 8704,
  parameter int unsigned VALID_EDGES = 8960
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_i,
  input  logic       err_i,
  input  logic       dbl,
  input  logic       slave,
  output ocs_state_e state,
  output logic       capture,
  output logic       go_run
);
  localparam int unsigned CW = $clog2(2 * VALID_EDGES + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] cal_len;
  logic [CW-1:0] valid_len;

  assign cal_len   = CW'(ocs_len(CAL_EDGES, dbl, slave));
  assign valid_len = CW'(ocs_len(VALID_EDGES, dbl, slave));
  assign cnt_nx    = cnt + 1'b1;
  assign capture   = edge_i && !err_i && (state == ST_CAL) && (cnt_nx == cal_len);
  assign go_run    = edge_i && !err_i &&
                     ((state == ST_RUN) || ((state == ST_SETTLE) && (cnt_nx == valid_len)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else if (err_i) begin
      state <= ST_CAL;
      cnt   <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          state <= ST_CAL;
          cnt   <= '0;
        end
        ST_CAL: if (edge_i) begin
          cnt <= cnt_nx;
          if (capture) state <= ST_SETTLE;
        end
        ST_SETTLE: if (edge_i) begin
          cnt <= cnt_nx;
          if (go_run) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ocs_offset_chan.sv
module ocs_offset_chan #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] raw,
  input  logic          capture,
  input  logic          upd,
  input  logic          go_run,
  output logic [DW-1:0] out
);
  logic [DW-1:0] off;

  // Signed difference clamped to the DW-bit two's-complement range
  function automatic logic [DW-1:0] sat_sub(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW:0] d;
    d = {a[DW-1], a} - {b[DW-1], b};
    if (d[DW] != d[DW-1]) return d[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return d[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off <= '0;
      out <= '0;
    end else begin
      if (capture) off <= raw;
      if (upd) out <= go_run ? sat_sub(raw, off) : '0;
    end
  end
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocs_pkg::*;
#(
  parameter int unsigned DW          = 24,
  parameter int unsigned CAL_EDGES   = 8704,
  parameter int unsigned VALID_EDGES = 8960,
  parameter int unsigned MCLK_PER_FS = 256
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic          lrck,
  input  logic          dbl_rate,
  input  logic          slave_mode,
  input  logic          cal_src_live,
  input  logic [DW-1:0] raw_l,
  input  logic [DW-1:0] raw_r,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          out_valid,
  output logic          cal,
  output logic          cal_src
);
  localparam int unsigned NCH = 2;

  logic       lrck_edge;
  logic       lock_err;
  logic       cap_pulse;
  logic       run_pulse;
  logic       upd;
  ocs_state_e state;

  logic [DW-1:0] raw_a [NCH];
  logic [DW-1:0] out_a [NCH];

  ocs_phase_mon #(.PER(MCLK_PER_FS)) u_phase (
    .clk(mclk), .rst_n(rst_n), .lrck(lrck), .dbl(dbl_rate),
    .edge_o(lrck_edge), .err_o(lock_err)
  );

  ocs_cal_fsm #(.CAL_EDGES(CAL_EDGES), .VALID_EDGES(VALID_EDGES)) u_fsm (
    .clk(mclk), .rst_n(rst_n), .edge_i(lrck_edge), .err_i(lock_err),
    .dbl(dbl_rate), .slave(slave_mode),
    .state(state), .capture(cap_pulse), .go_run(run_pulse)
  );

  assign upd      = lrck_edge || lock_err;
  assign raw_a[0] = raw_l;
  assign raw_a[1] = raw_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ocs_offset_chan #(.DW(DW)) u_chan (
      .clk(mclk), .rst_n(rst_n), .raw(raw_a[c]), .capture(cap_pulse),
      .upd(upd), .go_run(run_pulse), .out(out_a[c])
    );
  end

  assign out_l = out_a[0];
  assign out_r = out_a[1];

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (upd) out_valid <= run_pulse;
  end

  assign cal     = (state == ST_CAL);
  assign cal_src = cal ? cal_src_live : 1'b1;
endmodule

// File: rtl/ocs_checker.sv
module ocs_checker #(
  parameter int unsigned DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_i,
  input logic          err,
  input logic          capture,
  input logic          go_run,
  input logic          cal,
  input logic          valid,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_powerdown_r1: assert (!cal && !valid && out_l == '0 && out_r == '0)
        else $error("power-down state violated");
    end
  end

  p_capture_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !cal && !valid);

  p_cal_excludes_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cal |-> !valid);

  p_run_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_run |=> valid && !cal);

  p_zero_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (out_l == '0) && (out_r == '0));

  p_relock_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> cal && !valid);

  p_hold_between_edges_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i && !err) |=> $stable(out_l) && $stable(out_r) && $stable(valid));
endmodule

bind offset_cal_seq ocs_checker #(.DW(DW)) u_chk (
  .clk(mclk), .rst_n(rst_n), .edge_i(lrck_edge), .err(lock_err),
  .capture(cap_pulse), .go_run(run_pulse), .cal(cal), .valid(out_valid),
  .out_l(out_l), .out_r(out_r)
);

// File: tb/offset_cal_seq_test.sv
module offset_cal_seq_test;
  localparam int DW = 24;
  localparam int CE = 6;
  localparam int VE = 10;
  localparam int PF = 8;

  logic          mclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lrck = 1'b0;
  logic          dbl_rate = 1'b0;
  logic          slave_mode = 1'b0;
  logic          cal_src_live = 1'b1;
  logic [DW-1:0] raw_l = '0;
  logic [DW-1:0] raw_r = '0;
  logic [DW-1:0] out_l, out_r;
  logic          out_valid, cal, cal_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  offset_cal_seq #(.DW(DW), .CAL_EDGES(CE), .VALID_EDGES(VE), .MCLK_PER_FS(PF)) uut (
    .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .dbl_rate(dbl_rate),
    .slave_mode(slave_mode), .cal_src_live(cal_src_live),
    .raw_l(raw_l), .raw_r(raw_r), .out_l(out_l), .out_r(out_r),
    .out_valid(out_valid), .cal(cal), .cal_src(cal_src)
  );

  always #5 mclk = ~mclk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected corrected sample: signed difference, clamped to 24 bits
  function automatic logic [DW-1:0] expect_sub(logic [DW-1:0] a, logic [DW-1:0] b);
    longint d;
    d = longint'($signed(a)) - longint'($signed(b));
    if (d > 64'sd8388607) d = 8388607;
    if (d < -64'sd8388608) d = -8388608;
    return d[DW-1:0];
  endfunction

  // One sample period of per master cycles, starting at a falling mclk edge
  task automatic frame(input logic [DW-1:0] l, input logic [DW-1:0] r, input int per);
    lrck = 1'b1;
    raw_l = l;
    raw_r = r;
    repeat (per / 2) @(negedge mclk);
    lrck = 1'b0;
    repeat (per - per / 2) @(negedge mclk);
  endtask

  task automatic do_reset();
    @(negedge mclk);
    rst_n = 1'b0;
    lrck = 1'b0;
    repeat (3) @(negedge mclk);
    check(!cal && !out_valid && out_l == 0 && out_r == 0, "R1 reset state",
          {cal, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge mclk);
    check(cal == 1'b1, "R2 cal high after release", cal, 1);
    check(cal_src == cal_src_live, "R10 src forwarded during cal", cal_src, cal_src_live);
  endtask

  // Walk calibration edge by edge, then a sweep of run samples
  task automatic walk_cal(input int cl, input int vl, input int per,
                          input logic [DW-1:0] ol, input logic [DW-1:0] orr);
    logic [DW-1:0] l, r;
    for (int k = 1; k <= vl + 6; k++) begin
      if (k < cl) begin
        l = ol ^ DW'(k * 77);
        r = orr ^ DW'(k * 131 + 5);
      end else if (k == cl) begin
        l = ol;
        r = orr;
      end else begin
        case ((k - cl) % 6)
          0: begin l = 24'h7FFFF0; r = 24'h800010; end
          1: begin l = 24'h800000; r = 24'h7FFFFF; end
          2: begin l = ol;         r = orr;        end
          3: begin l = 24'h000000; r = 24'hFFFFFF; end
          4: begin l = 24'h123456; r = 24'hEDCBA9; end
          default: begin l = DW'(k * 9973); r = DW'(k * 40503); end
        endcase
      end
      frame(l, r, per);
      check(cal == (k < cl), (dbl_rate || slave_mode) ? "R3/R4 cal edge count" : "R2 cal edge count",
            cal, k < cl);
      check(out_valid == (k >= vl), (dbl_rate || slave_mode) ? "R3/R4 valid edge count" : "R5 valid edge count",
            out_valid, k >= vl);
      if (k >= vl) begin
        check(out_l == expect_sub(l, ol), "R6/R7 left corrected", out_l, expect_sub(l, ol));
        check(out_r == expect_sub(r, orr), "R6/R7 right corrected", out_r, expect_sub(r, orr));
      end else begin
        check(out_l == 0 && out_r == 0, "R8 zero while not valid", {out_l, out_r}, 0);
      end
      if (!cal) check(cal_src == 1'b1, "R10 src live outside cal", cal_src, 1);
    end
  endtask

  initial begin
    logic [DW-1:0] ofl, ofr;
    int per, cl, vl;
    for (int m = 0; m < 4; m++) begin
      dbl_rate     = m[1];
      slave_mode   = m[0];
      cal_src_live = m[0];
      per = dbl_rate ? PF / 2 : PF;
      cl  = (dbl_rate ? 2 * CE : CE) + (slave_mode ? 1 : 0);
      vl  = (dbl_rate ? 2 * VE : VE) + (slave_mode ? 1 : 0);
      ofl = (m == 0) ? 24'h900000 : DW'(24'h001234 * m);
      ofr = (m == 0) ? 24'h700000 : DW'(24'hFF0000 - 24'h000321 * m);
      do_reset();
      walk_cal(cl, vl, per, ofl, ofr);
    end

    // R7 explicit saturation corners with mode 0 offsets
    dbl_rate = 1'b0; slave_mode = 1'b0; cal_src_live = 1'b0;
    do_reset();
    walk_cal(CE, VE, PF, 24'h900000, 24'h700000);
    frame(24'h7FFFF0, 24'h800010, PF);
    check(out_l == 24'h7FFFFF, "R7 positive clamp", out_l, 24'h7FFFFF);
    check(out_r == 24'h800000, "R7 negative clamp", out_r, 24'h800000);

    // R9 short period: the edge that ends it is not counted
    frame(24'h000001, 24'h000002, PF - 2);
    frame(24'h000003, 24'h000004, PF);
    check(cal == 1'b1 && out_valid == 1'b0, "R9 short period restarts", {cal, out_valid}, 2'b10);
    check(out_l == 0 && out_r == 0, "R9 outputs zero after restart", {out_l, out_r}, 0);
    walk_cal(CE, VE, PF, 24'h00ABCD, 24'hFFF000);

    // R9 long gap: sample clock held low
    repeat (3 * PF) @(negedge mclk);
    check(cal == 1'b1 && out_valid == 1'b0, "R9 missing edge restarts", {cal, out_valid}, 2'b10);
    walk_cal(CE, VE, PF, 24'h400000, 24'hC00000);

    // R9 double rate expects half the period: a full-length frame is an error
    dbl_rate = 1'b1;
    do_reset();
    walk_cal(2 * CE, 2 * VE, PF / 2, 24'h000010, 24'h000020);
    frame(24'h0, 24'h0, PF);
    check(cal == 1'b1 && out_valid == 1'b0, "R9 double-rate period mismatch", {cal, out_valid}, 2'b10);

    // R11 outputs stay put between edges
    do_reset();
    walk_cal(2 * CE, 2 * VE, PF / 2, 24'h000100, 24'h000200);
    lrck = 1'b1; raw_l = 24'h000500; raw_r = 24'h000600;
    @(negedge mclk);
    raw_l = 24'h0F0F0F; raw_r = 24'h0E0E0E;
    @(negedge mclk);
    check(out_l == 24'h000400 && out_r == 24'h000400, "R11 edge sample held", out_l, 24'h000400);
    lrck = 1'b0;
    repeat (2) @(negedge mclk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule